// File: doc/BRIEF.md
# Write-Protect Register Controller

This block holds the protection register of a small serial memory. The register is mapped at the highest array address. The block decides, byte by byte, whether the memory acknowledges a write from the bus engine. When the engine reports a stop, the block decides whether the transaction updates the register, starts an array program cycle, or does nothing. The register holds two volatile enable latches and three nonvolatile protection bits. An external hardware protect pin, together with one of those bits, freezes the nonvolatile contents for good.

The bus engine sends three kinds of event:
- A transaction start, which carries the first byte address.
- One strobe for each received data byte. The block answers each strobe with a registered acknowledge decision.
- A stop.

For reads, the engine presents the address together with a flag that says whether the read is random or part of a sequential stream. The block then reports whether the register, rather than the array byte, must be returned. The register contents are always available on a read-data port.

Volatile latches clear on reset. The nonvolatile bits are loaded on reset from a parameter that stands in for the stored cell contents.

Top module: `wp_guard`

## Requirements
- R1: After reset, the write enable latch and the register enable latch are 0, and the protection bits equal the NV_INIT parameter. The register read data layout is: bit 7 protect-enable, bits 4:3 lock field (bit 4 high, bit 3 low), bit 2 register enable latch, bit 1 write enable latch, and bits 6, 5 and 0 reading 0.
- R2: While the write enable latch is 0, the first data byte of a write to any address other than the top is not acknowledged (ack_ok=0), and its stop starts no array cycle.
- R3: The top-address data byte of any write is acknowledged. A single-byte write at the top of value 0000001x sets the write enable latch. A single-byte write of 00000000 clears both latches.
- R4: A single-byte top write of 0000011x, or of pattern p00qr110, sets the register enable latch only when the write enable latch is 1. It never alters the protection bits. With the write enable latch at 0, these values are ignored.
- R5: With the register enable latch at 1, a single-byte top write of pattern p00qr010 stores protect-enable=p and lock field={q,r}. It clears the register enable latch and pulses prog_reg. With the latch at 0, the same value does not touch the protection bits.
- R6: Lock field meanings: 00 locks nothing; 01 locks addresses whose two top bits are 11; 10 locks addresses whose top bit is 1; 11 locks every array address. An array byte that falls in the locked region is not acknowledged. The register stays writable under lock field 11.
- R7: While hw_protect is 1 and protect-enable is 1, a protection-bit store is rejected: no prog_reg pulse, and all state, including the register enable latch, is unchanged. With hw_protect at 0 the store proceeds.
- R8: A random read of the top address sets rd_reg_sel to 1. A sequential read through the top address, or a read of any other address, sets it to 0.
- R9: A multi-byte write that starts at the top address is an array write. It leaves the register unchanged. It starts an array cycle only if the write enable latch is 1 and the top address is not locked.
- R10: Once a byte in a transaction is refused, every later byte of that transaction is refused. The stop then starts no cycle of either kind.
- R11: ack_vld/ack_ok appear one cycle after a byte strobe. prog_reg, prog_arr and the register update appear one cycle after the stop.
- R12: Byte addresses within a sector write advance in the low log2(SECT_BYTES) address bits only, wrapping inside the sector. Lock checks use that wrapped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_protect | input | 1 | Hardware protect pin level |
| wr_start | input | 1 | Start of a write transaction, qualifies wr_addr |
| wr_addr | input | AW | First byte address of the write |
| wr_byte_vld | input | 1 | One received data byte |
| wr_byte | input | 8 | Data byte value |
| wr_stop | input | 1 | Stop closing the write transaction |
| rd_req | input | 1 | Read access request |
| rd_addr | input | AW | Address being read |
| rd_seq | input | 1 | 1 when the read continues a sequential stream |
| ack_vld | output | 1 | Acknowledge decision valid |
| ack_ok | output | 1 | 1 = acknowledge the byte, 0 = no acknowledge |
| prog_reg | output | 1 | Pulse: nonvolatile register update starts |
| prog_arr | output | 1 | Pulse: array program cycle starts |
| rd_reg_sel | output | 1 | Last read returns the register instead of the array |
| reg_rdata | output | 8 | Current register contents |

## Verification
The assertions assume the bus engine sends at most one event per cycle. They also assume byte strobes and stops arrive only after a transaction start, and that a new start never coincides with a byte. Under those assumptions they can relate each acknowledge to its byte and each program pulse to the latch state in the stop cycle. The stimulus drives every event for exactly one cycle on a falling edge. It always separates start, bytes and stop by at least one cycle, and it holds the protect pin steady across each transaction. So every latch and lock value the assertions sample is the one the decision was made on.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef struct packed {
    logic       ppen;
    logic [1:0] bl;
    logic       rwel;
    logic       wel;
  } wp_state_t;

  typedef struct packed {
    logic clr_all;
    logic set_wel;
    logic set_rwel;
    logic nv_store;
  } wp_act_t;

  function automatic logic [7:0] pack_reg(input wp_state_t s);
    return {s.ppen, 2'b00, s.bl, s.rwel, s.wel, 1'b0};
  endfunction

endpackage

// File: rtl/wp_lock_map.sv
module wp_lock_map #(
  parameter int AW = 13
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    bl,
  output logic          locked
);
  always_comb begin
    unique case (bl)
      2'b00:   locked = 1'b0;
      2'b01:   locked = &addr[AW-1:AW-2];
      2'b10:   locked = addr[AW-1];
      default: locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/wp_cmd_decode.sv
module wp_cmd_decode
  import wp_pkg::*;
(
  input  logic [7:0] data,
  input  wp_state_t  cur,
  input  logic       hw_lock,
  output wp_act_t    act
);
  logic nv_pat, rw_pat, we_pat, clr_pat;

  always_comb begin
    nv_pat  = (data[6:5] == 2'b00) && (data[2:0] == 3'b010);
    rw_pat  = (data[7:1] == 7'b0000011) ||
              ((data[6:5] == 2'b00) && (data[2:0] == 3'b110));
    we_pat  = (data[7:1] == 7'b0000001);
    clr_pat = (data == 8'h00);
    act     = '0;
    if (cur.rwel && nv_pat) begin
      act.nv_store = !hw_lock;
    end else if (clr_pat) begin
      act.clr_all = 1'b1;
    end else if (we_pat) begin
      act.set_wel = 1'b1;
    end else if (rw_pat && cur.wel) begin
      act.set_rwel = 1'b1;
    end
  end
endmodule

// File: rtl/wp_state_reg.sv
module wp_state_reg
  import wp_pkg::*;
#(
  parameter logic [7:0] NV_INIT = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       apply,
  input  wp_act_t    act,
  input  logic [7:0] data,
  output wp_state_t  st
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st.wel  <= 1'b0;
      st.rwel <= 1'b0;
      st.ppen <= NV_INIT[7];
      st.bl   <= NV_INIT[4:3];
    end else if (apply) begin
      if (act.clr_all) begin
        st.wel  <= 1'b0;
        st.rwel <= 1'b0;
      end
      if (act.set_wel)  st.wel  <= 1'b1;
      if (act.set_rwel) st.rwel <= 1'b1;
      if (act.nv_store) begin
        st.ppen <= data[7];
        st.bl   <= data[4:3];
        st.rwel <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int         AW         = 13,
  parameter int         SECT_BYTES = 32,
  parameter logic [7:0] NV_INIT    = 8'h00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hw_protect,
  input  logic          wr_start,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_byte_vld,
  input  logic [7:0]    wr_byte,
  input  logic          wr_stop,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_seq,
  output logic          ack_vld,
  output logic          ack_ok,
  output logic          prog_reg,
  output logic          prog_arr,
  output logic          rd_reg_sel,
  output logic [7:0]    reg_rdata
);
  localparam int            SW  = $clog2(SECT_BYTES);
  localparam int            CW  = SW + 1;
  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  logic [AW-1:0] base_q;
  logic [CW-1:0] cnt_q;
  logic          bad_q, in_wr_q;
  logic [7:0]    first_q;
  logic [AW-1:0] cur_addr;
  logic          lock_cur, lock_top, hw_lock, byte_ok;
  logic          reg_txn, arr_ok;
  wp_state_t     st;
  wp_act_t       act;

  logic [SW-1:0] low_sum;
  assign low_sum  = base_q[SW-1:0] + cnt_q[SW-1:0];
  assign cur_addr = {base_q[AW-1:SW], low_sum};
  assign hw_lock  = hw_protect && st.ppen;

  wp_lock_map #(.AW(AW)) u_lock_cur (.addr(cur_addr), .bl(st.bl), .locked(lock_cur));
  wp_lock_map #(.AW(AW)) u_lock_top (.addr(TOP),      .bl(st.bl), .locked(lock_top));

  wp_cmd_decode u_dec (.data(first_q), .cur(st), .hw_lock(hw_lock), .act(act));

  always_comb begin
    byte_ok = !bad_q &&
              (((cnt_q == '0) && (base_q == TOP)) || (st.wel && !lock_cur));
    reg_txn = !bad_q && (cnt_q == CW'(1)) && (base_q == TOP);
    arr_ok  = !bad_q && (cnt_q != '0) && !reg_txn &&
              ((base_q != TOP) || (st.wel && !lock_top));
  end

  wp_state_reg #(.NV_INIT(NV_INIT)) u_state (
    .clk(clk), .rst(rst),
    .apply(in_wr_q && wr_stop && !wr_start && reg_txn),
    .act(act), .data(first_q), .st(st)
  );

  assign reg_rdata = pack_reg(st);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q     <= '0;
      cnt_q      <= '0;
      bad_q      <= 1'b0;
      in_wr_q    <= 1'b0;
      first_q    <= '0;
      ack_vld    <= 1'b0;
      ack_ok     <= 1'b0;
      prog_reg   <= 1'b0;
      prog_arr   <= 1'b0;
      rd_reg_sel <= 1'b0;
    end else begin
      ack_vld  <= 1'b0;
      ack_ok   <= 1'b0;
      prog_reg <= 1'b0;
      prog_arr <= 1'b0;
      if (wr_start) begin
        base_q  <= wr_addr;
        cnt_q   <= '0;
        bad_q   <= 1'b0;
        in_wr_q <= 1'b1;
      end else if (in_wr_q && wr_byte_vld) begin
        ack_vld <= 1'b1;
        ack_ok  <= byte_ok;
        if (cnt_q == '0) first_q <= wr_byte;
        if (cnt_q != '1) cnt_q <= cnt_q + CW'(1);
        if (!byte_ok) bad_q <= 1'b1;
      end else if (in_wr_q && wr_stop) begin
        in_wr_q  <= 1'b0;
        prog_reg <= reg_txn && act.nv_store;
        prog_arr <= arr_ok;
      end
      if (rd_req) rd_reg_sel <= (rd_addr == TOP) && !rd_seq;
    end
  end
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       hw_protect,
  input logic       wr_byte_vld,
  input logic       ack_vld,
  input logic       prog_reg,
  input logic       prog_arr,
  input logic [7:0] reg_rdata
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (reg_rdata[2:1] == 2'b00 && !prog_reg && !prog_arr));

  // R11
  ack_follows_byte_chk: assert property (@(posedge clk) disable iff (rst)
    ack_vld |-> $past(wr_byte_vld));

  // R5
  nv_store_drops_rwel_chk: assert property (@(posedge clk) disable iff (rst)
    prog_reg |-> (!reg_rdata[2] && $past(reg_rdata[2])));

  // R7
  hw_lock_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    prog_reg |-> !$past(hw_protect && reg_rdata[7]));

  // R5
  nv_bits_only_on_store_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable({reg_rdata[7], reg_rdata[4:3]}) |-> (prog_reg || $past(rst)));

  // R4
  rwel_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_rdata[2]) |-> $past(reg_rdata[1]));

  // R2
  arr_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
    prog_arr |-> $past(reg_rdata[1]));

  // R1
  zero_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[6:5] == 2'b00 && !reg_rdata[0]));
endmodule

bind wp_guard wp_guard_chk u_chk (
  .clk(clk), .rst(rst), .hw_protect(hw_protect), .wr_byte_vld(wr_byte_vld),
  .ack_vld(ack_vld), .prog_reg(prog_reg), .prog_arr(prog_arr),
  .reg_rdata(reg_rdata)
);

// File: tb/wp_guard_tb.sv
`timescale 1ns/100ps
module wp_guard_tb_top;
  localparam int AW = 13;
  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hw_protect = 1'b0;
  logic wr_start = 1'b0, wr_byte_vld = 1'b0, wr_stop = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_byte = '0;
  logic rd_req = 1'b0, rd_seq = 1'b0;
  logic ack_vld, ack_ok, prog_reg, prog_arr, rd_reg_sel;
  logic [7:0] reg_rdata;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wp_guard #(.AW(AW), .SECT_BYTES(32), .NV_INIT(8'h00)) dut_i (
    .clk(clk), .rst(rst), .hw_protect(hw_protect),
    .wr_start(wr_start), .wr_addr(wr_addr), .wr_byte_vld(wr_byte_vld),
    .wr_byte(wr_byte), .wr_stop(wr_stop), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_seq(rd_seq), .ack_vld(ack_vld), .ack_ok(ack_ok),
    .prog_reg(prog_reg), .prog_arr(prog_arr), .rd_reg_sel(rd_reg_sel),
    .reg_rdata(reg_rdata)
  );

  // row: {hw_protect, data byte, expected register, expected prog_reg}
  localparam int NV = 14;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 8'h06, 8'h00, 1'b0},  // R4 ignored without WEL
    {1'b0, 8'h03, 8'h02, 1'b0},  // R3 set WEL
    {1'b0, 8'h1A, 8'h02, 1'b0},  // R5 no store without RWEL
    {1'b0, 8'h07, 8'h06, 1'b0},  // R4 set RWEL
    {1'b0, 8'h1E, 8'h06, 1'b0},  // R4 p00qr110 only RWEL
    {1'b0, 8'h1A, 8'h1A, 1'b1},  // R5 store BL=11
    {1'b0, 8'h00, 8'h18, 1'b0},  // R3 clear
    {1'b0, 8'h02, 8'h1A, 1'b0},  // R3 set WEL
    {1'b0, 8'h06, 8'h1E, 1'b0},  // R4
    {1'b0, 8'h8A, 8'h8A, 1'b1},  // R5 PPEN=1 BL=01
    {1'b0, 8'h06, 8'h8E, 1'b0},  // R4
    {1'b1, 8'h02, 8'h8E, 1'b0},  // R7 store refused
    {1'b0, 8'h92, 8'h92, 1'b1},  // R7 pin low, store proceeds
    {1'b0, 8'h00, 8'h90, 1'b0}   // R3
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start_wr(input logic [AW-1:0] a);
    @(negedge clk); wr_addr = a; wr_start = 1'b1;
    @(negedge clk); wr_start = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input logic exp_ack, input string tag);
    wr_byte = d; wr_byte_vld = 1'b1;
    @(negedge clk); wr_byte_vld = 1'b0;
    chk({tag, " ack_vld"}, ack_vld, 1);
    chk({tag, " ack_ok"}, ack_ok, exp_ack);
  endtask

  task automatic stop_wr(input logic exp_arr, input logic exp_prog, input string tag);
    wr_stop = 1'b1;
    @(negedge clk); wr_stop = 1'b0;
    chk({tag, " prog_arr"}, prog_arr, exp_arr);
    chk({tag, " prog_reg"}, prog_reg, exp_prog);
  endtask

  task automatic reg_write(input logic [7:0] d, input logic [7:0] exp_reg,
                           input logic exp_prog, input string tag);
    start_wr(TOP);
    send_byte(d, 1'b1, tag);
    stop_wr(1'b0, exp_prog, tag);
    chk({tag, " reg"}, reg_rdata, exp_reg);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic seq, input logic exp, input string tag);
    @(negedge clk); rd_addr = a; rd_seq = seq; rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    chk(tag, rd_reg_sel, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset reg", reg_rdata, 8'h00);
    chk("R1 reset prog", {prog_reg, prog_arr, ack_vld}, 0);

    for (int i = 0; i < NV; i++) begin
      hw_protect = VEC[i][17];
      reg_write(VEC[i][16:9], VEC[i][8:1], VEC[i][0], $sformatf("R5/R7 vec%0d", i));
    end
    hw_protect = 1'b0;

    // R2: WEL=0, array write refused
    start_wr(13'h0040); send_byte(8'h55, 1'b0, "R2 nack");
    stop_wr(1'b0, 1'b0, "R2 stop");
    reg_write(8'h02, 8'h92, 1'b0, "R3 wel");
    // R11 accepted array write, pulse one cycle after stop
    start_wr(13'h0040); send_byte(8'h11, 1'b1, "R11 b0"); send_byte(8'h22, 1'b1, "R11 b1");
    stop_wr(1'b1, 1'b0, "R11 stop");
    // R6 / R10: lock field 10, upper half locked
    start_wr(13'h1020); send_byte(8'h11, 1'b0, "R6 locked");
    send_byte(8'h22, 1'b0, "R10 after nack"); stop_wr(1'b0, 1'b0, "R10 stop");
    // R12: wrap inside sector below lock boundary
    start_wr(13'h0FFE); send_byte(8'h01, 1'b1, "R12 b0"); send_byte(8'h02, 1'b1, "R12 b1");
    send_byte(8'h03, 1'b1, "R12 wrap"); stop_wr(1'b1, 1'b0, "R12 stop");
    // R9: multi-byte at top, wrapped byte locked
    start_wr(TOP); send_byte(8'h06, 1'b1, "R9 first"); send_byte(8'h06, 1'b0, "R9 locked");
    stop_wr(1'b0, 1'b0, "R9 stop");
    chk("R9 reg kept", reg_rdata, 8'h92);
    // clear locks, pin low
    reg_write(8'h06, 8'h96, 1'b0, "R4 rwel");
    reg_write(8'h02, 8'h02, 1'b1, "R5 clear bl");
    start_wr(TOP); send_byte(8'h06, 1'b1, "R9 top b0"); send_byte(8'h07, 1'b1, "R9 top b1");
    stop_wr(1'b1, 1'b0, "R9 arr");
    chk("R9 reg unchanged", reg_rdata, 8'h02);
    // R6: lock 11 locks array, register writable
    reg_write(8'h06, 8'h06, 1'b0, "R6 rwel");
    reg_write(8'h1A, 8'h1A, 1'b1, "R6 bl11");
    start_wr(13'h0000); send_byte(8'hAA, 1'b0, "R6 full lock");
    stop_wr(1'b0, 1'b0, "R6 stop");
    reg_write(8'h00, 8'h18, 1'b0, "R6 reg writable");
    // R8 reads
    do_read(TOP, 1'b0, 1'b1, "R8 random top");
    do_read(TOP, 1'b1, 1'b0, "R8 seq top");
    do_read(13'h0005, 1'b0, 1'b0, "R8 other");
    // R1 reset reloads
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 reset again", reg_rdata, 8'h00);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule